// File: doc/BRIEF.md
# Timer Channel Counter with Selectable Clear Source

This block is one channel of a multi-channel up-counting timer. It counts edges of a count-clock input that arrives already prescaled. A 2-bit edge field chooses rising edges, falling edges or both. The counter returns to zero when an event occurs on the general register chosen by a 3-bit clear-select field. Such an event is a compare-match or an input capture, depending on how the external register logic is set up. The counter can also return to zero whenever another synchronized channel clears its own counter. Each channel drives a one-cycle clear pulse out, and it takes in the OR of the pulses from its sibling channels.

The parameter `FULL_CH` sets the size of the channel. A full channel has four general registers (A to D). A reduced channel has two registers (A and B). On a reduced channel the top bit of the select field is reserved, and the channel can follow an external phase-count decoder instead of the clock edges.

Two small state machines do the work. The edge tracker has the states CK_LOW and CK_HIGH. It moves CK_LOW to CK_HIGH when the sampled count clock goes high, which marks a rising edge. It moves CK_HIGH to CK_LOW when the sampled count clock goes low, which marks a falling edge. The clear-source decoder holds one of the states SRC_NONE, SRC_A, SRC_B, SRC_C, SRC_D or SRC_SYNC. It moves between them only when the select field is written.

Top module: `timer_clear_channel`

## Requirements
- R1: After reset the counter is 0, the select field reads 000 and the clear pulse output is 0.
- R2: With edge field 00 the counter counts rising edges of the count clock only. The count changes on the second system clock edge after the count clock rises.
- R3: With edge field 01 the counter counts falling edges only.
- R4: With edge field 10 or 11 the counter counts both rising and falling edges.
- R5: With no clear, the counter wraps from 0xFFFF to 0.
- R6: Select code 001 clears on a register A event and 010 clears on a register B event. Events on other registers have no effect. A clear in the same cycle as an increment wins, and the counter loads 0.
- R7: On a full channel, code 101 clears on a register C event and 110 clears on a register D event. Codes 000 and 100 never clear the counter.
- R8: While register C (buffer flag bit 0) or register D (buffer flag bit 1) works as a buffer, its events never clear the counter.
- R9: Codes 011 and 111 clear the counter in the cycle where the sync input is high, but only when sync enable is 1. With sync enable 0 the sync input has no effect.
- R10: The clear pulse output is high in exactly the cycles where the channel clears from its own register event while sync enable is 1. The output stays low when the clear came from the sync input.
- R11: On a reduced channel, bit 2 of the select field always reads 0 and writes to it are ignored. A write of 101 therefore acts as 001, and register C/D events do nothing.
- R12: On a reduced channel in phase-count mode, the counter increments on each cycle where the phase count pulse is high, and the edge field and count clock are ignored. On a full channel the phase-count inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_wr | input | 1 | Write strobe for the clear-select field |
| sel_wdata | input | 3 | New clear-select code |
| sel_q | output | 3 | Current clear-select field |
| edge_sel | input | 2 | Count edge choice: 00 rising, 01 falling, 1x both |
| cnt_clk | input | 1 | Prescaled count clock, sampled on clk |
| phase_mode | input | 1 | Phase-count mode (reduced channel only) |
| phase_inc | input | 1 | Count pulse from the phase decoder |
| gr_event | input | 4 | Compare-match/capture event per register, bit 0 = A to bit 3 = D |
| gr_buffered | input | 2 | Bit 0: register C is a buffer; bit 1: register D is a buffer |
| sync_en | input | 1 | Channel takes part in synchronous clearing |
| sync_clr_in | input | 1 | OR of the other channels' clear pulses |
| sync_clr_out | output | 1 | One-cycle clear pulse to the other channels |
| count | output | CNT_W | Counter value |

## Verification
The bench builds two copies side by side on the same stimulus: one with `FULL_CH=1` and one with `FULL_CH=0`, both with a 16-bit counter. The full copy makes the C/D clear codes, buffer suppression and the 1xx codes reachable. The reduced copy shows the reserved select bit turning 101 into a register A clear, and the phase-count override of the edge field. A behavioural model runs for each copy and is compared on every cycle. The 16-bit width keeps the wrap from 0xFFFF within reach by counting on both edges of a clock that toggles every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic {
        CK_LOW  = 1'b0,
        CK_HIGH = 1'b1
    } edge_st_e;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_A    = 3'd1,
        SRC_B    = 3'd2,
        SRC_C    = 3'd3,
        SRC_D    = 3'd4,
        SRC_SYNC = 3'd5
    } clr_src_e;

    localparam logic [1:0] EDGE_RISE = 2'b00;
    localparam logic [1:0] EDGE_FALL = 2'b01;

endpackage

// File: rtl/tmr_edge_sel.sv
module tmr_edge_sel
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cnt_clk,
    input  logic [1:0] edge_sel,
    input  logic       phase_act,
    input  logic       phase_inc,
    output logic       inc
);

    logic     smp;
    edge_st_e st_q;
    edge_st_e st_d;
    logic     rise;
    logic     fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp  <= 1'b0;
            st_q <= CK_LOW;
        end else begin
            smp  <= cnt_clk;
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        rise = 1'b0;
        fall = 1'b0;
        unique case (st_q)
            CK_LOW: begin
                if (smp) begin
                    st_d = CK_HIGH;
                    rise = 1'b1;
                end
            end
            CK_HIGH: begin
                if (!smp) begin
                    st_d = CK_LOW;
                    fall = 1'b1;
                end
            end
        endcase
    end

    always_comb begin
        if (phase_act) begin
            inc = phase_inc;
        end else begin
            unique case (edge_sel)
                EDGE_RISE: inc = rise;
                EDGE_FALL: inc = fall;
                default:   inc = rise | fall;
            endcase
        end
    end

endmodule

// File: rtl/tmr_clr_sel.sv
module tmr_clr_sel
    import tmr_pkg::*;
#(
    parameter bit FULL_CH = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_wr,
    input  logic [2:0] sel_wdata,
    output logic [2:0] sel_q,
    input  logic [3:0] evt,
    input  logic [1:0] buf_cd,
    input  logic       sync_en,
    input  logic       sync_in,
    output logic       own_hit,
    output logic       clr_now
);

    localparam int         NREG     = FULL_CH ? 4 : 2;
    localparam logic [2:0] SEL_MASK = FULL_CH ? 3'b111 : 3'b011;

    logic [2:0] sel_r;
    logic [3:0] ev_ok;
    clr_src_e   src;
    logic       sync_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_r <= 3'b000;
        end else if (sel_wr) begin
            sel_r <= sel_wdata & SEL_MASK;
        end
    end

    assign sel_q = sel_r;

    for (genvar k = 0; k < 4; k++) begin : g_ev
        if (k >= NREG) begin : g_absent
            assign ev_ok[k] = 1'b0;
        end else if (k >= 2) begin : g_cd
            assign ev_ok[k] = evt[k] & ~buf_cd[k-2];
        end else begin : g_ab
            assign ev_ok[k] = evt[k];
        end
    end

    always_comb begin
        unique case (sel_r)
            3'b001:         src = SRC_A;
            3'b010:         src = SRC_B;
            3'b101:         src = SRC_C;
            3'b110:         src = SRC_D;
            3'b011, 3'b111: src = SRC_SYNC;
            default:        src = SRC_NONE;
        endcase
    end

    always_comb begin
        own_hit  = 1'b0;
        sync_hit = 1'b0;
        unique case (src)
            SRC_A:    own_hit  = ev_ok[0];
            SRC_B:    own_hit  = ev_ok[1];
            SRC_C:    own_hit  = ev_ok[2];
            SRC_D:    own_hit  = ev_ok[3];
            SRC_SYNC: sync_hit = sync_en & sync_in;
            default:  own_hit  = 1'b0;
        endcase
        clr_now = own_hit | sync_hit;
    end

endmodule

// File: rtl/timer_clear_channel.sv
module timer_clear_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter bit FULL_CH = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_wr,
    input  logic [2:0]       sel_wdata,
    output logic [2:0]       sel_q,
    input  logic [1:0]       edge_sel,
    input  logic             cnt_clk,
    input  logic             phase_mode,
    input  logic             phase_inc,
    input  logic [3:0]       gr_event,
    input  logic [1:0]       gr_buffered,
    input  logic             sync_en,
    input  logic             sync_clr_in,
    output logic             sync_clr_out,
    output logic [CNT_W-1:0] count
);

    localparam bit               PHASE_OK = !FULL_CH;
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    logic phase_act;
    logic inc;
    logic own_hit;
    logic clr_now;

    assign phase_act = PHASE_OK & phase_mode;

    tmr_edge_sel u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_clk   (cnt_clk),
        .edge_sel  (edge_sel),
        .phase_act (phase_act),
        .phase_inc (phase_inc),
        .inc       (inc)
    );

    tmr_clr_sel #(.FULL_CH(FULL_CH)) u_clr (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_wr    (sel_wr),
        .sel_wdata (sel_wdata),
        .sel_q     (sel_q),
        .evt       (gr_event),
        .buf_cd    (gr_buffered),
        .sync_en   (sync_en),
        .sync_in   (sync_clr_in),
        .own_hit   (own_hit),
        .clr_now   (clr_now)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr_now) begin
            count <= '0;
        end else if (inc) begin
            count <= count + ONE;
        end
    end

    assign sync_clr_out = own_hit & sync_en;

    // R2 / R5: the counter only steps by one or returns to zero
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> (count == $past(count) + ONE || count == '0));

    // R6: a decoded clear always leaves the counter at zero
    a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_now |=> (count == '0));

    // R10: an outgoing clear pulse is matched by this channel's own reset
    a_r10_pulse_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sync_clr_out |=> (count == '0));

    // R9: without sync enable and without register events, no clear happens
    a_r9_sync_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_en && gr_event == 4'b0000) |=>
            (count == $past(count) || count == $past(count) + ONE));

endmodule

// File: tb/test_timer_clear_channel.sv
module test_timer_clear_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_wr = 1'b0;
    logic [2:0]  sel_wdata = 3'b000;
    logic [1:0]  edge_sel = 2'b00;
    logic        cnt_clk = 1'b0;
    logic        phase_mode = 1'b0;
    logic        phase_inc = 1'b0;
    logic [3:0]  gr_event = 4'b0000;
    logic [1:0]  gr_buffered = 2'b00;
    logic        sync_en = 1'b0;
    logic        sync_clr_in = 1'b0;

    logic [2:0]  sel_q_f, sel_q_r;
    logic        sync_out_f, sync_out_r;
    logic [15:0] count_f, count_r;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 1'b0;

    // model state, index 0 = full channel, 1 = reduced channel
    logic        m_s1 [2];
    logic        m_lvl [2];
    logic [2:0]  m_fld [2];
    logic [15:0] m_cnt [2];
    logic        b_rise, b_fall, b_inc, b_hit;

    always #5 clk = ~clk;

    timer_clear_channel #(.CNT_W(16), .FULL_CH(1'b1)) i_timer_clear_channel (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wdata(sel_wdata), .sel_q(sel_q_f),
        .edge_sel(edge_sel), .cnt_clk(cnt_clk), .phase_mode(phase_mode), .phase_inc(phase_inc),
        .gr_event(gr_event), .gr_buffered(gr_buffered), .sync_en(sync_en),
        .sync_clr_in(sync_clr_in), .sync_clr_out(sync_out_f), .count(count_f)
    );

    timer_clear_channel #(.CNT_W(16), .FULL_CH(1'b0)) i_timer_clear_channel_red (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wdata(sel_wdata), .sel_q(sel_q_r),
        .edge_sel(edge_sel), .cnt_clk(cnt_clk), .phase_mode(phase_mode), .phase_inc(phase_inc),
        .gr_event(gr_event), .gr_buffered(gr_buffered), .sync_en(sync_en),
        .sync_clr_in(sync_clr_in), .sync_clr_out(sync_out_r), .count(count_r)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic own_ev(input bit full, input logic [2:0] f);
        case (f)
            3'b001:  return gr_event[0];
            3'b010:  return gr_event[1];
            3'b101:  return full && gr_event[2] && !gr_buffered[0];
            3'b110:  return full && gr_event[3] && !gr_buffered[1];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic sync_ev(input logic [2:0] f);
        return (f[1:0] == 2'b11) && sync_en && sync_clr_in;
    endfunction

    // behavioural reference, updated on each system clock edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_s1[i] = 1'b0; m_lvl[i] = 1'b0; m_fld[i] = 3'b000; m_cnt[i] = 16'd0;
            end
        end else begin
            for (int i = 0; i < 2; i++) begin
                b_rise = !m_lvl[i] && m_s1[i];
                b_fall = m_lvl[i] && !m_s1[i];
                if (i == 1 && phase_mode) b_inc = phase_inc;
                else if (edge_sel == 2'b00) b_inc = b_rise;
                else if (edge_sel == 2'b01) b_inc = b_fall;
                else b_inc = b_rise || b_fall;
                b_hit = own_ev(i == 0, m_fld[i]) || sync_ev(m_fld[i]);
                if (b_hit) m_cnt[i] = 16'd0;
                else if (b_inc) m_cnt[i] = m_cnt[i] + 16'd1;
                m_lvl[i] = m_s1[i];
                m_s1[i] = cnt_clk;
                if (sel_wr) m_fld[i] = (i == 0) ? sel_wdata : {1'b0, sel_wdata[1:0]};
            end
        end
    end

    // every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 model count full", 32'(count_f), 32'(m_cnt[0]));
            chk("R12 model count reduced", 32'(count_r), 32'(m_cnt[1]));
            chk("R11 model select full", 32'(sel_q_f), 32'(m_fld[0]));
            chk("R11 model select reduced", 32'(sel_q_r), 32'(m_fld[1]));
            chk("R10 model pulse full", 32'(sync_out_f), 32'(own_ev(1'b1, m_fld[0]) && sync_en));
            chk("R10 model pulse reduced", 32'(sync_out_r), 32'(own_ev(1'b0, m_fld[1]) && sync_en));
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 190000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog R5 actual=%0d expected=%0d", cyc, 190000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr_sel(input logic [2:0] v);
        sel_wr = 1'b1; sel_wdata = v;
        step(1);
        sel_wr = 1'b0;
    endtask

    task automatic pulse_ev(input logic [3:0] v);
        gr_event = v;
        step(1);
        gr_event = 4'b0000;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        // R1
        chk("R1 reset count full", 32'(count_f), 32'h0);
        chk("R1 reset count reduced", 32'(count_r), 32'h0);
        chk("R1 reset select", 32'(sel_q_f), 32'h0);
        chk("R1 reset pulse", 32'(sync_out_f), 32'h0);

        // R2: rising edges, second clock edge latency
        edge_sel = 2'b00;
        cnt_clk = 1'b1; step(1);
        chk("R2 not yet counted", 32'(count_f), 32'h0);
        step(1);
        chk("R2 rising counted", 32'(count_f), 32'h1);
        cnt_clk = 1'b0; step(2);
        chk("R2 falling ignored", 32'(count_f), 32'h1);
        cnt_clk = 1'b1; step(2);
        chk("R2 second rise", 32'(count_f), 32'h2);

        // R3: falling edges only
        edge_sel = 2'b01;
        cnt_clk = 1'b0; step(2);
        chk("R3 falling counted", 32'(count_f), 32'h3);
        cnt_clk = 1'b1; step(2);
        chk("R3 rising ignored", 32'(count_f), 32'h3);

        // R4: both edges
        edge_sel = 2'b10;
        cnt_clk = 1'b0; step(2);
        chk("R4 both fall", 32'(count_f), 32'h4);
        cnt_clk = 1'b1; step(2);
        chk("R4 both rise", 32'(count_f), 32'h5);
        edge_sel = 2'b11;
        cnt_clk = 1'b0; step(2);
        chk("R4 code 11 fall", 32'(count_f), 32'h6);

        // R6: register A/B clears, clear beats increment
        wr_sel(3'b001);
        chk("R6 select written", 32'(sel_q_f), 32'h1);
        pulse_ev(4'b0010);
        chk("R6 B ignored under A", 32'(count_f), 32'h6);
        cnt_clk = 1'b1; step(1);
        gr_event = 4'b0001; #1;
        chk("R10 no pulse without sync enable", 32'(sync_out_f), 32'h0);
        step(1);
        gr_event = 4'b0000;
        chk("R6 clear wins over increment", 32'(count_f), 32'h0);
        chk("R6 clear wins reduced", 32'(count_r), 32'h0);

        // R7 / R11: register C on full, reserved bit on reduced
        wr_sel(3'b101);
        chk("R7 full select 101", 32'(sel_q_f), 32'h5);
        chk("R11 reduced reads 001", 32'(sel_q_r), 32'h1);
        cnt_clk = 1'b0; step(2);
        chk("R7 full counted", 32'(count_f), 32'h1);
        pulse_ev(4'b0100);
        chk("R7 C clears full", 32'(count_f), 32'h0);
        chk("R11 C ignored reduced", 32'(count_r), 32'h1);
        pulse_ev(4'b0001);
        chk("R11 A clears reduced", 32'(count_r), 32'h0);
        cnt_clk = 1'b1; step(2);
        wr_sel(3'b110);
        pulse_ev(4'b1000);
        chk("R7 D clears full", 32'(count_f), 32'h0);
        chk("R11 D ignored reduced", 32'(count_r), 32'h1);
        wr_sel(3'b100);
        cnt_clk = 1'b0; step(2);
        pulse_ev(4'b1111);
        chk("R7 code 100 no clear", 32'(count_f), 32'h1);
        chk("R7 code 000 no clear reduced", 32'(count_r), 32'h2);

        // R8: buffer suppression
        wr_sel(3'b101);
        gr_buffered = 2'b01;
        pulse_ev(4'b0100);
        chk("R8 C buffered no clear", 32'(count_f), 32'h1);
        wr_sel(3'b110);
        gr_buffered = 2'b10;
        pulse_ev(4'b1000);
        chk("R8 D buffered no clear", 32'(count_f), 32'h1);
        gr_buffered = 2'b00;
        pulse_ev(4'b1000);
        chk("R8 D unbuffered clears", 32'(count_f), 32'h0);

        // R9: synchronous clear
        wr_sel(3'b011);
        cnt_clk = 1'b1; step(2);
        chk("R9 setup full", 32'(count_f), 32'h1);
        sync_clr_in = 1'b1; sync_en = 1'b0;
        step(1);
        chk("R9 ignored without enable", 32'(count_f), 32'h1);
        sync_en = 1'b1; #1;
        chk("R10 no echo of sync clear", 32'(sync_out_f), 32'h0);
        step(1);
        sync_clr_in = 1'b0;
        chk("R9 sync clears full", 32'(count_f), 32'h0);
        chk("R9 sync clears reduced", 32'(count_r), 32'h0);

        // R10: outgoing pulse on own clear
        wr_sel(3'b001);
        cnt_clk = 1'b0; step(2);
        gr_event = 4'b0001; #1;
        chk("R10 pulse full", 32'(sync_out_f), 32'h1);
        chk("R10 pulse reduced", 32'(sync_out_r), 32'h1);
        step(1);
        gr_event = 4'b0000; #1;
        chk("R10 pulse ends", 32'(sync_out_f), 32'h0);
        chk("R10 cleared", 32'(count_f), 32'h0);
        sync_en = 1'b0;

        // R12: phase-count mode
        edge_sel = 2'b00;
        phase_mode = 1'b1; phase_inc = 1'b1; cnt_clk = 1'b1;
        step(3);
        phase_mode = 1'b0; phase_inc = 1'b0;
        chk("R12 reduced follows phase pulses", 32'(count_r), 32'h3);
        chk("R12 full ignores phase mode", 32'(count_f), 32'h1);

        // R5: wrap
        wr_sel(3'b000);
        edge_sel = 2'b10;
        for (int n = 0; n < 70000 && count_f != 16'hFFFF; n++) begin
            cnt_clk = ~cnt_clk;
            step(1);
        end
        chk("R5 reached top", 32'(count_f), 32'hFFFF);
        step(1);
        chk("R5 wraps to zero", 32'(count_f), 32'h0);
        step(2);
        chk("R5 stays after wrap", 32'(count_f), 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule